// File: doc/BRIEF.md
# Character Fetch and Pixel Serializer

This block sits beside a host CPU and turns the CPU's own instruction fetches into video. The CPU is made to "execute" a line of the display area through an address window with the top address bit set. Each fetched byte that is a printable character is captured by the block, and the CPU receives an all-zero no-op in its place. The CPU therefore only steps its program counter through the line, while the block collects character codes. A byte with bit 6 set, normally the end-of-line code 0x76, passes through unchanged, so the CPU executes it as a halt.

In the refresh half of the same fetch, the block builds a glyph-memory address from three parts: the captured code, a base taken from the CPU's upper address lines, and a scanline row counter that hsync advances. It issues one read and loads the returned byte into a shifter. The shifter emits one pixel per clock, most significant bit first, and inverts the byte when bit 7 of the code was set.

The block runs entirely on the pixel clock, which is twice the CPU rate. A one-cycle strobe marks each CPU clock.

Top module: `charfetch_serializer`

## Requirements
- R1: A synchronous active-low reset clears the captured code, the row counter and the shifter. After reset `pix_out` is 0, no glyph read occurs, and the row field starts at 0. A code captured before a reset produces no read afterwards.
- R2: While `bus_m1` is 1, `bus_addr[ADDR_W-1]` is 1 and `mem_data[6]` is 0, `cpu_data` is 0x00.
- R3: In every other case `cpu_data` equals `mem_data`. This covers a display fetch of a byte with bit 6 set (such as 0x76), a fetch with the top address bit 0, and a non-fetch access.
- R4: `glyph_rd` is high for exactly one clock per display fetch of a printable byte. That clock is the strobed cycle of the second CPU clock with `bus_rfsh` high. Fetches outside the window, and bytes with bit 6 set, produce no read.
- R5: `glyph_addr` is {`bus_addr[12:9]`, code bits 5..0, row[2:0]}, with the row in bits 2..0, the code in bits 8..3 and the base in bits 12..9.
- R6: The row counter advances by one on each rising edge of `hsync` and wraps from 7 to 0. It holds otherwise.
- R7: The glyph byte returned ROM_LAT clocks after the read is shown most significant bit first, one bit per clock. The first pixel appears ROM_LAT+1 clocks after the `glyph_rd` cycle.
- R8: When bit 7 of the captured code is 1, the 8 pixels are the complement of the glyph byte.
- R9: When no shifted data is pending, `pix_out` is 0.
- R10: Display fetches issued back to back, one every four CPU clocks, yield an unbroken pixel stream with no blank clock between characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, twice the CPU clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_ce | input | 1 | One-clock strobe marking each CPU clock |
| bus_addr | input | ADDR_W (16) | CPU address bus |
| bus_m1 | input | 1 | Instruction fetch cycle, active high |
| bus_rfsh | input | 1 | Refresh cycle, active high |
| mem_data | input | 8 | Byte from memory |
| cpu_data | output | 8 | Byte presented to the CPU |
| hsync | input | 1 | Horizontal sync; each rising edge steps the row |
| glyph_rd | output | 1 | Glyph memory read strobe |
| glyph_addr | output | BASE_W+CODE_W+ROW_W (13) | Glyph memory address |
| glyph_data | input | PIX_W (8) | Glyph byte, valid ROM_LAT clocks after the read |
| pix_out | output | 1 | Serial pixel, 1 = lit |

## Verification
The hardest situation to reach from the ports is a reset that lands inside a fetch. The code has already been captured on the second CPU clock, but the refresh half that would read it has not yet arrived. The bench drives every CPU clock through its own task call, so it can assert reset between the second and third clocks of a fetch and then finish the refresh half. The scoreboard then expects no read, and expects blank pixels throughout. A second hard case is a full 32-character line issued back to back. There, each new shifter load falls in the very clock that shows the previous glyph's last bit, so any gap or overlap appears as a blank or misordered pixel.

// File: rtl/charfetch_pkg.sv
package charfetch_pkg;
   localparam int unsigned BYTE_W        = 8;
   localparam int unsigned CTRL_BIT      = 6;  // set: control byte, executed by the CPU
   localparam int unsigned INV_BIT       = 7;  // set: inverse video
   localparam int unsigned CODE_BITS_MAX = 6;  // glyph index lives below the control bit
   localparam logic [BYTE_W-1:0] NOP_BYTE = '0;

   function automatic logic is_printable(input logic [BYTE_W-1:0] b);
      return !b[CTRL_BIT];
   endfunction
endpackage

// File: rtl/charfetch_decode.sv
module charfetch_decode
   import charfetch_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned CODE_W   = 6,
   parameter int unsigned BASE_W   = 4,
   parameter int unsigned BASE_LSB = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_ce,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_m1,
   input  logic                bus_rfsh,
   input  logic [BYTE_W-1:0]   mem_data,
   output logic [BYTE_W-1:0]   cpu_data,
   output logic                rd_req,
   output logic [CODE_W-1:0]   rd_code,
   output logic                rd_inv,
   output logic [BASE_W-1:0]   rd_base
);
   localparam int unsigned SEL_BIT = ADDR_W - 1;

   logic              disp_hit;
   logic              m1_q;
   logic              rf_q;
   logic              vld_q;
   logic [CODE_W-1:0] code_q;
   logic              inv_q;
   logic              unused_addr_bits;

   assign unused_addr_bits = ^bus_addr;

   // Display fetch of a printable byte: substitute a no-op.
   assign disp_hit = bus_m1 && bus_addr[SEL_BIT] && is_printable(mem_data);
   assign cpu_data = disp_hit ? NOP_BYTE : mem_data;

   // Second refresh clock (refresh seen on the previous CPU clock too).
   assign rd_req  = cpu_ce && bus_rfsh && rf_q && vld_q;
   assign rd_code = code_q;
   assign rd_inv  = inv_q;
   assign rd_base = bus_addr[BASE_LSB +: BASE_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m1_q   <= 1'b0;
         rf_q   <= 1'b0;
         vld_q  <= 1'b0;
         code_q <= '0;
         inv_q  <= 1'b0;
      end else if (cpu_ce) begin
         m1_q <= bus_m1;
         rf_q <= bus_rfsh;
         if (disp_hit && m1_q) begin
            // second fetch clock: capture the character
            code_q <= mem_data[CODE_W-1:0];
            inv_q  <= mem_data[INV_BIT];
            vld_q  <= 1'b1;
         end else if (rd_req || (bus_m1 && !m1_q)) begin
            vld_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/charfetch_rowctr.sv
module charfetch_rowctr #(
   parameter int unsigned ROW_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync,
   output logic [ROW_W-1:0] row
);
   logic hs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_q <= 1'b0;
         row  <= '0;
      end else begin
         hs_q <= hsync;
         if (hsync && !hs_q) begin
            row <= row + ROW_W'(1);
         end
      end
   end
endmodule

// File: rtl/charfetch_shifter.sv
module charfetch_shifter #(
   parameter int unsigned PIX_W   = 8,
   parameter int unsigned ROM_LAT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  logic             rd_inv,
   input  logic [PIX_W-1:0] glyph_data,
   output logic             pix_out
);
   localparam int unsigned CNT_W = $clog2(PIX_W + 1);

   logic [ROM_LAT-1:0] vld_pipe;
   logic [ROM_LAT-1:0] inv_pipe;
   logic               load;
   logic               load_inv;
   logic [PIX_W-1:0]   sr;
   logic [CNT_W-1:0]   left;

   // Delay line matching the glyph memory latency.
   generate
      if (ROM_LAT == 1) begin : g_lat_one
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_pipe <= '0;
               inv_pipe <= '0;
            end else begin
               vld_pipe <= rd_req;
               inv_pipe <= rd_inv;
            end
         end
      end else begin : g_lat_many
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_pipe <= '0;
               inv_pipe <= '0;
            end else begin
               vld_pipe <= {vld_pipe[ROM_LAT-2:0], rd_req};
               inv_pipe <= {inv_pipe[ROM_LAT-2:0], rd_inv};
            end
         end
      end
   endgenerate

   assign load     = vld_pipe[ROM_LAT-1];
   assign load_inv = inv_pipe[ROM_LAT-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr   <= '0;
         left <= '0;
      end else if (load) begin
         sr   <= glyph_data ^ {PIX_W{load_inv}};
         left <= CNT_W'(PIX_W);
      end else if (left != '0) begin
         sr   <= sr << 1;
         left <= left - CNT_W'(1);
      end
   end

   assign pix_out = (left != '0) && sr[PIX_W-1];
endmodule

// File: rtl/charfetch_serializer.sv
module charfetch_serializer
   import charfetch_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned CODE_W  = 6,
   parameter int unsigned BASE_W  = 4,
   parameter int unsigned ROW_W   = 3,
   parameter int unsigned PIX_W   = 8,
   parameter int unsigned ROM_LAT = 1,
   localparam int unsigned GLYPH_AW = BASE_W + CODE_W + ROW_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_ce,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_m1,
   input  logic                bus_rfsh,
   input  logic [7:0]          mem_data,
   output logic [7:0]          cpu_data,
   input  logic                hsync,
   output logic                glyph_rd,
   output logic [GLYPH_AW-1:0] glyph_addr,
   input  logic [PIX_W-1:0]    glyph_data,
   output logic                pix_out
);
   localparam int unsigned BASE_LSB = CODE_W + ROW_W;

   generate
      if (CODE_W < 1 || CODE_W > CODE_BITS_MAX) begin : g_bad_code
         $error("CODE_W must lie in 1..%0d", CODE_BITS_MAX);
      end
      if (BASE_LSB + BASE_W > ADDR_W - 1) begin : g_bad_base
         $error("base lines overlap the display window bit");
      end
      if (ROM_LAT < 1) begin : g_bad_lat
         $error("ROM_LAT must be at least 1");
      end
      if (ROW_W < 1 || PIX_W < 1) begin : g_bad_geom
         $error("ROW_W and PIX_W must be positive");
      end
   endgenerate

   logic [CODE_W-1:0] rd_code;
   logic [BASE_W-1:0] rd_base;
   logic              rd_inv;
   logic [ROW_W-1:0]  row;

   charfetch_decode #(
      .ADDR_W  (ADDR_W),
      .CODE_W  (CODE_W),
      .BASE_W  (BASE_W),
      .BASE_LSB(BASE_LSB)
   ) u_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .cpu_ce  (cpu_ce),
      .bus_addr(bus_addr),
      .bus_m1  (bus_m1),
      .bus_rfsh(bus_rfsh),
      .mem_data(mem_data),
      .cpu_data(cpu_data),
      .rd_req  (glyph_rd),
      .rd_code (rd_code),
      .rd_inv  (rd_inv),
      .rd_base (rd_base)
   );

   charfetch_rowctr #(
      .ROW_W(ROW_W)
   ) u_rowctr (
      .clk  (clk),
      .rst_n(rst_n),
      .hsync(hsync),
      .row  (row)
   );

   charfetch_shifter #(
      .PIX_W  (PIX_W),
      .ROM_LAT(ROM_LAT)
   ) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_req    (glyph_rd),
      .rd_inv    (rd_inv),
      .glyph_data(glyph_data),
      .pix_out   (pix_out)
   );

   assign glyph_addr = {rd_base, rd_code, row};
endmodule

// File: rtl/charfetch_chk.sv
module charfetch_chk #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned ROW_W    = 3,
   parameter int unsigned GLYPH_AW = 13
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cpu_ce,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_m1,
   input logic                bus_rfsh,
   input logic [7:0]          mem_data,
   input logic [7:0]          cpu_data,
   input logic                hsync,
   input logic                glyph_rd,
   input logic [GLYPH_AW-1:0] glyph_addr
);
   AST_NOP_ON_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_m1 && bus_addr[ADDR_W-1] && !mem_data[6]) |-> (cpu_data == 8'h00)); // R2

   AST_CTRL_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      mem_data[6] |-> (cpu_data == mem_data)); // R3

   AST_READ_IN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
      glyph_rd |-> (bus_rfsh && cpu_ce && !bus_m1)); // R4

   AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      glyph_rd |=> !glyph_rd); // R4

   AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hsync) |=> (glyph_addr[ROW_W-1:0] ==
                        ROW_W'($past(glyph_addr[ROW_W-1:0]) + ROW_W'(1)))); // R6

   AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(hsync) |=> $stable(glyph_addr[ROW_W-1:0])); // R6
endmodule

bind charfetch_serializer charfetch_chk #(
   .ADDR_W  (ADDR_W),
   .ROW_W   (ROW_W),
   .GLYPH_AW(GLYPH_AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_ce    (cpu_ce),
   .bus_addr  (bus_addr),
   .bus_m1    (bus_m1),
   .bus_rfsh  (bus_rfsh),
   .mem_data  (mem_data),
   .cpu_data  (cpu_data),
   .hsync     (hsync),
   .glyph_rd  (glyph_rd),
   .glyph_addr(glyph_addr)
);

// File: tb/charfetch_serializer_tb_top.sv
module charfetch_serializer_tb_top;
   localparam int ROM_LAT = 1;
   localparam int GAW     = 13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_ce = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_m1 = 1'b0;
   logic        bus_rfsh = 1'b0;
   logic [7:0]  mem_data = '0;
   logic        hsync = 1'b0;
   logic [7:0]  glyph_data = '0;
   logic [7:0]  cpu_data;
   logic        glyph_rd;
   logic [12:0] glyph_addr;
   logic        pix_out;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int row_m = 0;
   bit finished = 1'b0;

   // scoreboard queues: expected reads, then expected pixels
   logic [GAW-1:0] ea_q[$];
   logic [7:0]     ep_q[$];
   string          et_q[$];
   int             due_q[$];
   bit             val_q[$];
   string          tag_q[$];

   always #2 clk = ~clk;  // 250 MHz

   charfetch_serializer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_ce    (cpu_ce),
      .bus_addr  (bus_addr),
      .bus_m1    (bus_m1),
      .bus_rfsh  (bus_rfsh),
      .mem_data  (mem_data),
      .cpu_data  (cpu_data),
      .hsync     (hsync),
      .glyph_rd  (glyph_rd),
      .glyph_addr(glyph_addr),
      .glyph_data(glyph_data),
      .pix_out   (pix_out)
   );

   function automatic logic [7:0] rom_f(input logic [GAW-1:0] a);
      return (a[7:0] * 8'd29) ^ {3'b000, a[12:8]} ^ 8'hA5;
   endfunction

   // glyph memory model, one clock of latency
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (glyph_rd) glyph_data <= rom_f(glyph_addr);
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor
   always @(negedge clk) begin
      logic [GAW-1:0] ea;
      logic [7:0]     ep;
      string          et;
      if (rst_n && !finished) begin
         if (glyph_rd) begin
            if (ea_q.size() == 0) begin
               chk(1'b0, "R4", "unexpected glyph read", int'(glyph_addr), 0);
            end else begin
               ea = ea_q.pop_front();
               ep = ep_q.pop_front();
               et = et_q.pop_front();
               chk(glyph_addr == ea, "R5", "glyph address", int'(glyph_addr), int'(ea));
               for (int i = 0; i < 8; i++) begin
                  due_q.push_back(cyc + ROM_LAT + 1 + i);
                  val_q.push_back(ep[7-i]);
                  tag_q.push_back(et);
               end
            end
         end
         if (due_q.size() != 0 && due_q[0] == cyc) begin
            void'(due_q.pop_front());
            chk(pix_out == val_q[0], tag_q[0], "pixel bit", int'(pix_out), int'(val_q[0]));
            void'(val_q.pop_front());
            void'(tag_q.pop_front());
         end else begin
            chk(pix_out == 1'b0, "R9", "blank pixel", int'(pix_out), 0);
         end
      end
   end

   task automatic cpu_clk(input bit m1, input bit rf, input logic [15:0] a,
                          input logic [7:0] d);
      @(posedge clk); #1;
      cpu_ce = 1'b1; bus_m1 = m1; bus_rfsh = rf; bus_addr = a; mem_data = d;
      @(posedge clk); #1;
      cpu_ce = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cpu_clk(1'b0, 1'b0, 16'h0000, 8'h3C);
   endtask

   // one display fetch: two fetch clocks, two refresh clocks
   task automatic display_fetch(input logic [14:0] off, input logic [7:0] code,
                                input logic [3:0] base);
      logic [GAW-1:0] a;
      cpu_clk(1'b1, 1'b0, {1'b1, off}, code);
      if (code[6]) chk(cpu_data == code, "R3", "control byte passes", int'(cpu_data), int'(code));
      else         chk(cpu_data == 8'h00, "R2", "no-op substituted", int'(cpu_data), 0);
      cpu_clk(1'b1, 1'b0, {1'b1, off}, code);
      if (!code[6]) begin
         a = {base, code[5:0], row_m[2:0]};
         ea_q.push_back(a);
         ep_q.push_back(rom_f(a) ^ {8{code[7]}});
         et_q.push_back(code[7] ? "R8" : "R7");
      end
      cpu_clk(1'b0, 1'b1, {3'b000, base, 9'h000}, 8'hFF);
      cpu_clk(1'b0, 1'b1, {3'b000, base, 9'h000}, 8'hFF);
   endtask

   task automatic hs_pulse();
      @(posedge clk); #1; hsync = 1'b1;
      @(posedge clk); #1; hsync = 1'b0;
      row_m = (row_m + 1) % 8;
   endtask

   task automatic drain();
      idle(12);
      chk(ea_q.size() == 0, "R4", "all expected reads issued", ea_q.size(), 0);
      chk(due_q.size() == 0, "R7", "all pixels shown", due_q.size(), 0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(pix_out == 1'b0, "R1", "pix after reset", int'(pix_out), 0);
      chk(glyph_rd == 1'b0, "R1", "no read after reset", int'(glyph_rd), 0);
      chk(cpu_data == mem_data, "R1", "bus passes after reset", int'(cpu_data), int'(mem_data));
      chk(glyph_addr[2:0] == 3'd0, "R1", "row cleared", int'(glyph_addr[2:0]), 0);

      // R7 single plain character, R8 inverse character
      display_fetch(15'h0010, 8'h05, 4'hF);
      drain();
      display_fetch(15'h0011, 8'h85, 4'hF);
      drain();
      display_fetch(15'h0012, 8'hBF, 4'h3);
      drain();

      // R3: non-display fetch and non-fetch access pass through, no read
      cpu_clk(1'b1, 1'b0, 16'h4123, 8'h15);
      chk(cpu_data == 8'h15, "R3", "fetch below window", int'(cpu_data), 8'h15);
      cpu_clk(1'b1, 1'b0, 16'h4123, 8'h15);
      cpu_clk(1'b0, 1'b1, 16'h1E00, 8'hFF);
      cpu_clk(1'b0, 1'b1, 16'h1E00, 8'hFF);
      cpu_clk(1'b0, 1'b0, 16'h8200, 8'h21);
      chk(cpu_data == 8'h21, "R3", "data read in window", int'(cpu_data), 8'h21);
      drain();

      // R6: row steps and wraps
      hs_pulse();
      display_fetch(15'h0020, 8'h2A, 4'h5);
      for (int i = 0; i < 6; i++) hs_pulse();
      display_fetch(15'h0021, 8'h2B, 4'h5);  // row 7
      hs_pulse(); hs_pulse();                // wraps to 1
      display_fetch(15'h0022, 8'h2C, 4'h5);
      drain();

      // R10: full line back to back, terminated by the end-of-line code
      for (int i = 0; i < 32; i++) begin
         logic [7:0] c;
         c = 8'((i * 5) & 8'h3F) | ((i % 3 == 0) ? 8'h80 : 8'h00);
         display_fetch(15'(16'h0100 + i), c, 4'hA);
      end
      display_fetch(15'h0120, 8'h76, 4'hA);  // R3 end-of-line: executed, no read
      drain();

      // R1: reset between capture and refresh cancels the read and clears the row
      hs_pulse(); hs_pulse();
      cpu_clk(1'b1, 1'b0, 16'h8200, 8'h11);
      cpu_clk(1'b1, 1'b0, 16'h8200, 8'h11);
      @(posedge clk); #1 rst_n = 1'b0;
      @(posedge clk); @(posedge clk); #1 rst_n = 1'b1;
      row_m = 0;
      cpu_clk(1'b0, 1'b1, 16'h1E00, 8'hFF);
      cpu_clk(1'b0, 1'b1, 16'h1E00, 8'hFF);
      drain();
      display_fetch(15'h0030, 8'h09, 4'h2);  // R1 row back to 0 (address check)
      drain();

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule